// File: doc/BRIEF.md
# Packetized Result Readout Buffer

This block sits between an internal measurement engine and a host processor. The engine pushes 32-bit result words into a buffer of 64 words. The host collects them over a parallel 32-bit bus with ordinary read strobes. A plain FIFO would hand out a word on every read. This block instead releases results only as whole packets of eight words, and three handshake signals frame each transfer.

The first signal is an interrupt, which tells the host that a complete packet is waiting. The second is a read-permitted flag, which says whether a packet can be taken now. The third is a level that the host drives high for as long as it is reading. The host may stop partway through a packet. The words it did not read stay at the head of the buffer, and the next burst picks them up. A read made when no complete packet is available returns zero and leaves a sticky underrun mark in a status word. The host reads that status word through a second bus select.

Top module: `result_readout`

## Requirements
- R1: After a synchronous reset the buffer is empty, `irq`, `rd_ok` and `almost_full` are low, and the status word reads as all zeros.
- R2: `irq` is high exactly while a complete packet is available and `host_burst` is low; it drops in the same cycle that `host_burst` rises.
- R3: `rd_ok` is high while the stored words, together with the words already taken from the packet at the head, make up at least one full packet of eight. Once raised, it stays high until the eighth word of that packet has been read.
- R4: A strobe with `rd_sel`=0, `host_burst` high and `rd_ok` high removes one word, which appears on `rd_data` in the cycle after the strobe. Words leave in the order in which they were written.
- R5: If `host_burst` falls partway through a packet, the unread words of that packet stay at the head, `irq` and `rd_ok` stay high, and the next burst continues with those words.
- R6: A data strobe (`rd_sel`=0) while `rd_ok` is low returns zero, leaves the stored count unchanged and sets the underrun bit, which is bit 0 of the status word. The bit stays set until reset.
- R7: A data strobe while `host_burst` is low returns zero and removes nothing, even when `rd_ok` is high.
- R8: Each cycle with `wr_valid` high stores one word while fewer than 64 words are held. A word offered while 64 are held is dropped, and the buffer contents do not change.
- R9: `almost_full` is high while 56 or more words are stored. That leaves room for one more packet.
- R10: A strobe with `rd_sel`=1 returns the status word one cycle later and removes nothing. Bits 14:8 carry the number of words stored, bit 0 carries the underrun mark, and every other bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers a result word this cycle |
| wr_data | input | 32 | Result word from the producer |
| almost_full | output | 1 | Producer should stall |
| rd_stb | input | 1 | Host read strobe, one cycle per word |
| rd_sel | input | 1 | 0 selects result data, 1 selects the status word |
| rd_data | output | 32 | Registered read data, valid the cycle after the strobe |
| host_burst | input | 1 | High while the host is reading results |
| irq | output | 1 | A complete packet is waiting |
| rd_ok | output | 1 | Reading a packet is permitted now |

## Verification
The assertions assume that the producer follows `almost_full` only loosely: writes into a full buffer are allowed and must be dropped. They also assume the host may strobe at any time, whatever the state of `rd_ok` or `host_burst`. The stimulus deliberately goes outside the normal protocol in three places: it reads an empty buffer, it reads without the burst level, and it keeps writing past 64 words. Each of these is paired with a status read that exposes the stored count and the underrun mark at the ports. All inputs change on the falling clock edge. Every strobe lasts exactly one cycle, so no strobe ever spans two rising edges.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int WORD_W    = 32;
    localparam int PKT_WORDS = 8;
    localparam int OFS_W     = $clog2(PKT_WORDS);

    typedef enum logic {
        SEL_DATA   = 1'b0,
        SEL_STATUS = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic [15:0] zero_hi;
        logic        zero_b15;
        logic [6:0]  words;
        logic [6:0]  zero_lo;
        logic        underrun;
    } status_t;

    function automatic logic [WORD_W-1:0] pack_status(logic under, logic [6:0] words);
        status_t s;
        s          = '0;
        s.words    = words;
        s.underrun = under;
        return s;
    endfunction

endpackage

// File: rtl/rdo_fifo.sv
module rdo_fifo
    import rdo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  cnt
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              push;

    assign push = push_req && (cnt < CNT_W'(DEPTH));
    assign head = mem[rptr];

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R8: the count never passes the capacity
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R8: a full buffer without a pop stays full, so the extra word is dropped
    a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(DEPTH) && !pop) |=> (cnt == CNT_W'(DEPTH)));

endmodule

// File: rtl/rdo_pkt_track.sv
module rdo_pkt_track
    import rdo_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic [CNT_W-1:0] cnt,
    input  logic             host_burst,
    output logic             pkt_ready,
    output logic             irq
);

    logic [OFS_W-1:0] head_ofs;
    logic [CNT_W:0]   span;

    // words of the current head packet, counted from its first word
    assign span      = {1'b0, cnt} + (CNT_W + 1)'(head_ofs);
    assign pkt_ready = span >= (CNT_W + 1)'(PKT_WORDS);
    assign irq       = pkt_ready && !host_burst;

    always_ff @(posedge clk) begin
        if (rst)      head_ofs <= '0;
        else if (pop) head_ofs <= head_ofs + 1'b1;
    end

    // R3: the permission flag only falls on a pop
    a_r3_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (pkt_ready && !pop) |=> pkt_ready);

    // R3: the eighth word of a packet closes it
    a_r3_ofs_wraps: assert property (@(posedge clk) disable iff (rst)
        (pop && head_ofs == OFS_W'(PKT_WORDS - 1)) |=> (head_ofs == '0));

endmodule

// File: rtl/rdo_bus.sv
module rdo_bus
    import rdo_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  rd_sel_e           rd_sel,
    input  logic              host_burst,
    input  logic              pkt_ready,
    input  logic [WORD_W-1:0] head,
    input  logic [CNT_W-1:0]  cnt,
    output logic              pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              underrun
);

    logic data_stb;

    assign data_stb = rd_stb && (rd_sel == SEL_DATA);
    assign pop      = data_stb && host_burst && pkt_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            underrun <= 1'b0;
        end else begin
            if (data_stb && !pkt_ready) underrun <= 1'b1;
            if (rd_stb) begin
                if (rd_sel == SEL_STATUS) rd_data <= pack_status(underrun, 7'(cnt));
                else if (pop)             rd_data <= head;
                else                      rd_data <= '0;
            end
        end
    end

    // R6: the underrun mark is sticky
    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R6: a data read without a packet returns zero and marks underrun
    a_r6_zero_on_empty: assert property (@(posedge clk) disable iff (rst)
        (data_stb && !pkt_ready) |=> (rd_data == '0 && underrun));

    // R7: a data read outside a burst returns zero
    a_r7_no_burst_zero: assert property (@(posedge clk) disable iff (rst)
        (data_stb && !host_burst) |=> (rd_data == '0));

endmodule

// File: rtl/result_readout.sv
module result_readout
    import rdo_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int AF_ROOM = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              almost_full,
    input  logic              rd_stb,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              host_burst,
    output logic              irq,
    output logic              rd_ok
);

    logic              pop;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  cnt;
    logic              pkt_ready;
    logic              underrun;

    rdo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_valid),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .cnt       (cnt)
    );

    rdo_pkt_track #(.CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .pop        (pop),
        .cnt        (cnt),
        .host_burst (host_burst),
        .pkt_ready  (pkt_ready),
        .irq        (irq)
    );

    rdo_bus #(.CNT_W(CNT_W)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .rd_stb     (rd_stb),
        .rd_sel     (rd_sel_e'(rd_sel)),
        .host_burst (host_burst),
        .pkt_ready  (pkt_ready),
        .head       (head),
        .cnt        (cnt),
        .pop        (pop),
        .rd_data    (rd_data),
        .underrun   (underrun)
    );

    assign rd_ok       = pkt_ready;
    assign almost_full = cnt >= CNT_W'(DEPTH - AF_ROOM);

    // R2: the interrupt is quiet during a burst
    a_r2_irq_quiet_in_burst: assert property (@(posedge clk) disable iff (rst)
        host_burst |-> !irq);

    // R9: the stall request is up whenever the buffer is full
    a_r9_af_when_full: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(DEPTH)) |-> almost_full);

endmodule

// File: tb/test_result_readout.sv
module test_result_readout;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        almost_full;
    logic        rd_stb = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        host_burst = 1'b0;
    logic        irq;
    logic        rd_ok;

    int total = 0;
    int bad   = 0;
    logic exp_under = 1'b0;
    logic [31:0] mdl[$];
    logic [31:0] seed = 32'h1000_0000;
    bit finished = 0;

    always #(CLK_PER / 2) clk = ~clk;

    result_readout i_result_readout (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .almost_full(almost_full), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data), .host_burst(host_burst), .irq(irq), .rd_ok(rd_ok)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {16'b0, 1'b0, 7'(mdl.size()), 7'b0, exp_under};
    endfunction

    task automatic write_words(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            seed     = seed * 32'd1103515245 + 32'd12345;
            wr_data  = seed;
            if (mdl.size() < 64) mdl.push_back(seed);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic bus_read(logic sel, output logic [31:0] val);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_sel = sel;
        @(negedge clk);
        rd_stb = 1'b0;
        val    = rd_data;
    endtask

    task automatic set_burst(logic b);
        @(negedge clk);
        host_burst = b;
        #1;
    endtask

    task automatic read_expect_head(string req);
        logic [31:0] v;
        bus_read(1'b0, v);
        check(req, v, mdl.pop_front());
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", 32'(irq), 0);
        check("R1 rd_ok", 32'(rd_ok), 0);
        check("R1 almost_full", 32'(almost_full), 0);
        bus_read(1'b1, v);
        check("R1 R10 status after reset", v, 32'h0);
    endtask

    task automatic t_packet_edge();
        write_words(7);
        check("R3 seven words not ready", 32'(rd_ok), 0);
        check("R2 seven words no irq", 32'(irq), 0);
        write_words(1);
        check("R3 eight words ready", 32'(rd_ok), 1);
        check("R2 irq on full packet", 32'(irq), 1);
        set_burst(1'b1);
        check("R2 irq drops in burst", 32'(irq), 0);
        set_burst(1'b0);
        check("R2 irq back after burst", 32'(irq), 1);
    endtask

    task automatic t_no_burst_read();
        logic [31:0] v;
        bus_read(1'b0, v);
        check("R7 read without burst is zero", v, 32'h0);
        bus_read(1'b1, v);
        check("R7 R10 nothing removed", v, exp_status());
    endtask

    task automatic t_full_read();
        set_burst(1'b1);
        for (int i = 0; i < 7; i++) read_expect_head("R4 packet word");
        check("R3 ready until eighth word", 32'(rd_ok), 1);
        read_expect_head("R4 eighth word");
        check("R3 ready drops after eighth", 32'(rd_ok), 0);
        set_burst(1'b0);
    endtask

    task automatic t_resume();
        write_words(8);
        set_burst(1'b1);
        for (int i = 0; i < 3; i++) read_expect_head("R5 first part");
        set_burst(1'b0);
        check("R5 irq after partial burst", 32'(irq), 1);
        check("R5 rd_ok after partial burst", 32'(rd_ok), 1);
        set_burst(1'b1);
        for (int i = 0; i < 5; i++) read_expect_head("R5 resumed words");
        check("R5 packet closed", 32'(rd_ok), 0);
        set_burst(1'b0);
    endtask

    task automatic t_fill();
        logic [31:0] v;
        write_words(55);
        check("R9 55 words no stall", 32'(almost_full), 0);
        write_words(1);
        check("R9 56 words stall", 32'(almost_full), 1);
        write_words(14);
        bus_read(1'b1, v);
        check("R8 R10 count capped at 64", v, exp_status());
        set_burst(1'b1);
        for (int i = 0; i < 64; i++) read_expect_head("R8 R4 drain order");
        check("R8 empty after drain", 32'(rd_ok), 0);
        check("R9 stall released", 32'(almost_full), 0);
        set_burst(1'b0);
    endtask

    task automatic t_underrun();
        logic [31:0] v;
        set_burst(1'b1);
        bus_read(1'b0, v);
        check("R6 empty read is zero", v, 32'h0);
        exp_under = 1'b1;
        set_burst(1'b0);
        write_words(3);
        bus_read(1'b1, v);
        check("R6 R10 underrun marked", v, exp_status());
        set_burst(1'b1);
        bus_read(1'b0, v);
        check("R6 partial packet read is zero", v, 32'h0);
        set_burst(1'b0);
        bus_read(1'b1, v);
        check("R6 underrun sticky, count kept", v, exp_status());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_packet_edge();
        t_no_burst_read();
        t_full_read();
        t_resume();
        t_fill();
        t_underrun();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule